// File: doc/BRIEF.md
# SPI NOR Flash Erase Model with Die-Scoped Erase

This block is a serial-flash slave for simulation platforms. It holds a small byte array split into a power-of-two number of stacked dies. It listens on a four-wire SPI bus in mode 0 with single-bit data. The SPI pins are oversampled by the system clock `clk`, so SCK has to run several times slower than `clk`. The block decodes a small command set: write-enable, status read, data read, sector erase, whole-array erase, die erase, and the two commands that switch between 3-byte and 4-byte addressing.

Die erase clears only the die that holds the supplied address. That die is found by aligning the address down to a boundary of array size divided by die count. When the die count parameter is zero, die erase is refused. No byte changes, the write-enable latch drops, and `die_err` is high for one clock. Whole-array erase stays available in every configuration. After an erase starts, a busy flag stays up for a fixed number of clocks.

Command state machine. The states are `ST_IDLE`, `ST_OPCODE`, `ST_ADDR`, `ST_ARMED`, `ST_READ`, `ST_STATUS` and `ST_DRAIN`. The transitions are:
- Chip select falling moves `ST_IDLE` to `ST_OPCODE`.
- From `ST_OPCODE`, a complete opcode byte goes to:
  - `ST_ARMED` for write-enable, whole-array erase and the address-mode commands.
  - `ST_STATUS` for status read.
  - `ST_ADDR` for read, sector erase and die erase.
  - `ST_DRAIN` for unknown opcodes, and for any opcode other than status read while busy.
- From `ST_ADDR`, the last address byte goes to `ST_READ` for a read, or to `ST_ARMED` otherwise.
- Chip select rising returns every state to `ST_IDLE`. Only from `ST_ARMED` is the latched command carried out.

Top module: `nor_die_erase_flash`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch when chip select rises. Opcode 0x05 returns the status byte on every following byte. In the status byte, bit 0 is busy, bit 1 is the write-enable latch, and bits 7..2 are zero. After reset the status byte is 0x00.
- R2: Opcode 0x03, followed by an address sent MSB first, streams bytes from consecutive addresses. After reset, byte i holds i mod 128. An erased byte reads 0xFF.
- R3: Erase and read commands take 3 address bytes after reset. Opcode 0xB7 switches them to 4 address bytes, and opcode 0xE9 switches them back to 3.
- R4: Opcode 0xD8 sets to 0xFF the SECTOR_BYTES-sized region that holds the address, aligned down to a sector boundary.
- R5: Opcode 0xC4 sets to 0xFF only the region of MEM_BYTES/DIE_COUNT bytes that holds the address, aligned down to that size. Bytes outside that region keep their values.
- R6: Opcode 0xC7 sets the whole array to 0xFF, whatever the value of DIE_COUNT, including zero.
- R7: With DIE_COUNT = 0, an enabled die erase changes no byte, clears the write-enable latch and raises `die_err` for exactly one clock. With DIE_COUNT > 0, `die_err` never rises.
- R8: An erase sent while the write-enable latch is clear changes no byte and does not set busy.
- R9: A command runs only when chip select rises after its last address byte. If chip select rises with the address incomplete, the command is discarded and the write-enable latch keeps its value.
- R10: Busy reads 1 for ERASE_CYCLES clocks after an erase starts. The write-enable latch stays set during that time and clears when the erase ends.
- R11: While busy, every opcode except 0x05 is ignored, and MISO returns 0x00 for the rest of that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| die_err | output | 1 | One-clock pulse when a die erase is refused |

## Verification
A MISO bit is due about four `clk` cycles after a falling SCK edge: two synchroniser stages, one edge-detect register and the output register. The bench therefore drives SCK low and samples MISO a full half-period of six cycles later, just before it raises SCK. Erases start three to four cycles after chip select rises. Busy is checked by a status read that completes well inside ERASE_CYCLES, and again after ERASE_CYCLES plus a 200-cycle margin, when both busy and the latch must be clear. The `die_err` pulse is counted on every falling `clk` edge, so a pulse of one clock adds exactly one to the count.

// File: rtl/nor_pkg.sv
package nor_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_ARMED,
        ST_READ,
        ST_STATUS,
        ST_DRAIN
    } fsm_t;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_SECT  = 8'hD8;
    localparam logic [7:0] OP_BULK  = 8'hC7;
    localparam logic [7:0] OP_DIE   = 8'hC4;
    localparam logic [7:0] OP_ADDR4 = 8'hB7;
    localparam logic [7:0] OP_ADDR3 = 8'hE9;

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/nor_spi_port.sv
module nor_spi_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       sel,
    output logic       cs_fall,
    output logic       cs_rise,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       miso
);
    logic [1:0] sck_s, cs_s, mosi_s;
    logic       sck_q, cs_q;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sh, tx_sh;
    logic       sck_rise, sck_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_s  <= 2'b00;
            cs_s   <= 2'b11;
            mosi_s <= 2'b00;
            sck_q  <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sck_s  <= {sck_s[0], sck};
            cs_s   <= {cs_s[0], cs_n};
            mosi_s <= {mosi_s[0], mosi};
            sck_q  <= sck_s[1];
            cs_q   <= cs_s[1];
        end
    end

    assign sck_rise = sck_s[1] & ~sck_q;
    assign sck_fall = ~sck_s[1] & sck_q;
    assign sel      = ~cs_s[1];
    assign cs_fall  = ~cs_s[1] & cs_q;
    assign cs_rise  = cs_s[1] & ~cs_q;
    assign rx_byte  = rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!sel) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                rx_sh   <= {rx_sh[6:0], mosi_s[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) rx_valid <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miso  <= 1'b0;
            tx_sh <= '0;
        end else if (!sel) begin
            miso  <= 1'b0;
            tx_sh <= '0;
        end else if (sck_fall) begin
            if (bit_cnt == 3'd0) begin
                miso  <= tx_byte[7];
                tx_sh <= {tx_byte[6:0], 1'b0};
            end else begin
                miso  <= tx_sh[7];
                tx_sh <= {tx_sh[6:0], 1'b0};
            end
        end
    end

    // R1: a byte is only reported while the device is selected
    p_rx_selected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sel));

endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
    parameter int BYTES = 1024,
    localparam int AW   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_base,
    input  logic [AW-1:0] clr_keep,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [BYTES];
    logic [AW-1:0] base_al;

    assign base_al = clr_base & ~clr_keep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem[i] <= {1'b0, 7'(i)};
        end else if (clr_en) begin
            for (int i = 0; i < BYTES; i++) begin
                if ((AW'(i) & ~clr_keep) == base_al) mem[i] <= 8'hFF;
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
    parameter int CYCLES = 256,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (start)        cnt <= CW'(CYCLES);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    // R11: a new erase never starts on top of a running one
    p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R10: busy falls right after the final count
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/nor_die_erase_flash.sv
module nor_die_erase_flash #(
    parameter int MEM_BYTES    = 1024,
    parameter int DIE_COUNT    = 4,
    parameter int SECTOR_BYTES = 64,
    parameter int ERASE_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic die_err
);
    import nor_pkg::*;

    localparam int AW        = $clog2(MEM_BYTES);
    localparam int DIE_DIV   = (DIE_COUNT == 0) ? 1 : DIE_COUNT;
    localparam int DIE_BYTES = MEM_BYTES / DIE_DIV;
    localparam bit HAS_DIES  = (DIE_COUNT != 0);

    initial begin
        assert (is_pow2(MEM_BYTES)) else $error("MEM_BYTES must be a power of two");
        assert (DIE_COUNT == 0 || (is_pow2(DIE_COUNT) && DIE_COUNT <= MEM_BYTES))
            else $error("DIE_COUNT must be zero or a power of two not above MEM_BYTES");
        assert (is_pow2(SECTOR_BYTES) && SECTOR_BYTES <= MEM_BYTES)
            else $error("SECTOR_BYTES must be a power of two not above MEM_BYTES");
        assert (ERASE_CYCLES >= 1) else $error("ERASE_CYCLES must be at least 1");
    end

    logic          sel, cs_fall, cs_rise, rx_valid;
    logic [7:0]    rx_byte, tx_byte, rd_data;
    fsm_t          state, nxt;
    logic [7:0]    opcode;
    logic [AW-1:0] addr, rd_ptr, keep;
    logic [1:0]    addr_cnt;
    logic          addr_last, wel, addr4, wip, busy_done;
    logic          exec, erase_go, die_reject;

    nor_spi_port u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (spi_sck),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .tx_byte (tx_byte),
        .sel     (sel),
        .cs_fall (cs_fall),
        .cs_rise (cs_rise),
        .rx_valid(rx_valid),
        .rx_byte (rx_byte),
        .miso    (spi_miso)
    );

    nor_cell_array #(.BYTES(MEM_BYTES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (erase_go),
        .clr_base(addr),
        .clr_keep(keep),
        .rd_addr (rd_ptr),
        .rd_data (rd_data)
    );

    nor_busy_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(erase_go),
        .busy (wip),
        .done (busy_done)
    );

    assign addr_last = (addr_cnt == (addr4 ? 2'd3 : 2'd2));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (cs_rise) begin
            nxt = ST_IDLE;
        end else if (cs_fall) begin
            nxt = ST_OPCODE;
        end else if (rx_valid) begin
            unique case (state)
                ST_OPCODE: begin
                    if (wip && rx_byte != OP_RDSR) begin
                        nxt = ST_DRAIN;
                    end else begin
                        case (rx_byte)
                            OP_WREN, OP_BULK, OP_ADDR4, OP_ADDR3: nxt = ST_ARMED;
                            OP_RDSR:                              nxt = ST_STATUS;
                            OP_READ, OP_SECT, OP_DIE:             nxt = ST_ADDR;
                            default:                              nxt = ST_DRAIN;
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (addr_last) nxt = (opcode == OP_READ) ? ST_READ : ST_ARMED;
                end
                default: nxt = state;
            endcase
        end
    end

    // execution decode
    assign exec       = cs_rise && (state == ST_ARMED) && !wip;
    assign die_reject = exec && wel && (opcode == OP_DIE) && !HAS_DIES;
    assign erase_go   = exec && wel &&
                        ((opcode == OP_SECT) || (opcode == OP_BULK) ||
                         ((opcode == OP_DIE) && HAS_DIES));

    always_comb begin
        unique case (opcode)
            OP_SECT: keep = AW'(SECTOR_BYTES - 1);
            OP_DIE:  keep = AW'(DIE_BYTES - 1);
            default: keep = AW'(MEM_BYTES - 1);
        endcase
    end

    always_comb begin
        unique case (state)
            ST_STATUS: tx_byte = {6'b0, wel, wip};
            ST_READ:   tx_byte = rd_data;
            default:   tx_byte = 8'h00;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode   <= 8'h00;
            addr     <= '0;
            addr_cnt <= '0;
            rd_ptr   <= '0;
            wel      <= 1'b0;
            addr4    <= 1'b0;
            die_err  <= 1'b0;
        end else begin
            die_err <= 1'b0;
            if (rx_valid && sel) begin
                unique case (state)
                    ST_OPCODE: begin
                        opcode   <= rx_byte;
                        addr     <= '0;
                        addr_cnt <= '0;
                    end
                    ST_ADDR: begin
                        addr     <= AW'({addr, rx_byte});
                        addr_cnt <= addr_cnt + 2'd1;
                        if (addr_last) rd_ptr <= AW'({addr, rx_byte});
                    end
                    ST_READ: rd_ptr <= rd_ptr + 1'b1;
                    default: ;
                endcase
            end
            if (busy_done) wel <= 1'b0;
            if (exec) begin
                case (opcode)
                    OP_WREN:  wel   <= 1'b1;
                    OP_ADDR4: addr4 <= 1'b1;
                    OP_ADDR3: addr4 <= 1'b0;
                    default: ;
                endcase
            end
            if (die_reject) begin
                die_err <= 1'b1;
                wel     <= 1'b0;
            end
        end
    end

    // R8: no erase starts without the write-enable latch
    p_go_needs_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> wel);
    // R7: the refusal flag is a single-clock pulse
    p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        die_err |=> !die_err);
    // R7: a refused die erase leaves the latch clear
    p_err_drops_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        die_err |-> !wel);
    // R3: the address counter never passes the active address length
    p_addr_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR) |-> (addr_cnt <= (addr4 ? 2'd3 : 2'd2)));
    // R10: the latch clears as the erase finishes
    p_wel_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_done |=> !wel);

endmodule

// File: tb/tb_nor_die_erase_flash.sv
module tb_nor_die_erase_flash;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 6;
    localparam int ERASE      = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, mosi = 1'b0, cs_a = 1'b1, cs_b = 1'b1;
    logic miso_a, miso_b, err_a, err_b;
    bit   pick_b = 1'b0;
    int   checks = 0, errors = 0;
    int   err_a_cnt = 0, err_b_cnt = 0;
    logic [7:0] rxb;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_die_erase_flash #(.MEM_BYTES(1024), .DIE_COUNT(4), .SECTOR_BYTES(64),
                          .ERASE_CYCLES(ERASE)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_a),
        .spi_mosi(mosi), .spi_miso(miso_a), .die_err(err_a));

    nor_die_erase_flash #(.MEM_BYTES(1024), .DIE_COUNT(0), .SECTOR_BYTES(64),
                          .ERASE_CYCLES(ERASE)) dut_nd (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_b),
        .spi_mosi(mosi), .spi_miso(miso_b), .die_err(err_b));

    always @(negedge clk) begin
        if (err_a) err_a_cnt++;
        if (err_b) err_b_cnt++;
    end

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            mosi = tx[b];
            tick(HP);
            rx[b] = pick_b ? miso_b : miso_a;
            sck = 1'b1;
            tick(HP);
            sck = 1'b0;
        end
    endtask

    task automatic open_txn(input bit to_b);
        pick_b = to_b;
        if (to_b) cs_b = 1'b0; else cs_a = 1'b0;
        tick(HP);
    endtask

    task automatic close_txn;
        tick(HP);
        cs_a = 1'b1;
        cs_b = 1'b1;
        tick(3 * HP);
    endtask

    task automatic send_addr(input logic [31:0] a, input int n);
        for (int k = n - 1; k >= 0; k--) xfer(a[8*k +: 8], rxb);
    endtask

    task automatic simple_cmd(input bit to_b, input logic [7:0] op);
        open_txn(to_b);
        xfer(op, rxb);
        close_txn();
    endtask

    task automatic get_status(input bit to_b, output logic [7:0] s);
        open_txn(to_b);
        xfer(8'h05, rxb);
        xfer(8'h00, s);
        close_txn();
    endtask

    task automatic read_one(input bit to_b, input int nab, input logic [31:0] a,
                            output logic [7:0] d);
        open_txn(to_b);
        xfer(8'h03, rxb);
        send_addr(a, nab);
        xfer(8'h00, d);
        close_txn();
    endtask

    task automatic erase_cmd(input bit to_b, input logic [7:0] op,
                             input logic [31:0] a, input int nab);
        open_txn(to_b);
        xfer(op, rxb);
        if (nab > 0) send_addr(a, nab);
        close_txn();
    endtask

    // reset state: status zero, pattern content
    task automatic t_reset;
        logic [7:0] v;
        get_status(0, v);
        check("R1 reset status", v, 8'h00);
        read_one(0, 3, 32'h010, v);
        check("R2 reset byte 0x010", v, 8'h10);
        read_one(0, 3, 32'h2C5, v);
        check("R2 reset byte 0x2C5", v, 8'h45);
    endtask

    task automatic t_no_wel;
        logic [7:0] v;
        erase_cmd(0, 8'hC4, 32'h000040, 3);
        get_status(0, v);
        check("R8 no busy without latch", v, 8'h00);
        read_one(0, 3, 32'h040, v);
        check("R8 byte kept", v, 8'h40);
    endtask

    task automatic t_partial;
        logic [7:0] v;
        simple_cmd(0, 8'h06);
        get_status(0, v);
        check("R1 latch set", v, 8'h02);
        erase_cmd(0, 8'hC4, 32'h0000, 2);
        get_status(0, v);
        check("R9 discarded, latch kept", v, 8'h02);
        read_one(0, 3, 32'h005, v);
        check("R9 byte kept", v, 8'h05);
    endtask

    task automatic t_sector_busy;
        logic [7:0] v;
        erase_cmd(0, 8'hD8, 32'h000345, 3);
        get_status(0, v);
        check("R10 busy with latch", v, 8'h03);
        read_one(0, 3, 32'h005, v);
        check("R11 read ignored while busy", v, 8'h00);
        tick(ERASE + 200);
        get_status(0, v);
        check("R10 idle, latch cleared", v, 8'h00);
        read_one(0, 3, 32'h33F, v);
        check("R4 below sector", v, 8'h3F);
        read_one(0, 3, 32'h340, v);
        check("R4 sector start", v, 8'hFF);
        read_one(0, 3, 32'h37F, v);
        check("R4 sector end", v, 8'hFF);
        read_one(0, 3, 32'h380, v);
        check("R4 above sector", v, 8'h00);
    endtask

    task automatic t_die3;
        logic [7:0] v;
        simple_cmd(0, 8'h06);
        erase_cmd(0, 8'hC4, 32'h000123, 3);
        tick(ERASE + 200);
        read_one(0, 3, 32'h0FF, v);
        check("R5 below die", v, 8'h7F);
        read_one(0, 3, 32'h100, v);
        check("R5 die start", v, 8'hFF);
        read_one(0, 3, 32'h1FF, v);
        check("R5 die end", v, 8'hFF);
        read_one(0, 3, 32'h200, v);
        check("R5 above die", v, 8'h00);
        check("R7 no pulse with dies", err_a_cnt, 0);
    endtask

    task automatic t_die4;
        logic [7:0] v;
        simple_cmd(0, 8'hB7);
        simple_cmd(0, 8'h06);
        erase_cmd(0, 8'hC4, 32'h00000280, 4);
        tick(ERASE + 200);
        read_one(0, 4, 32'h00000200, v);
        check("R3 4-byte die start", v, 8'hFF);
        read_one(0, 4, 32'h000002FF, v);
        check("R3 4-byte die end", v, 8'hFF);
        read_one(0, 4, 32'h00000300, v);
        check("R5 next die kept", v, 8'h00);
        simple_cmd(0, 8'hE9);
        read_one(0, 3, 32'h0003FE, v);
        check("R3 back to 3-byte", v, 8'h7E);
    endtask

    task automatic t_stream;
        logic [7:0] v;
        open_txn(0);
        xfer(8'h03, rxb);
        send_addr(32'h0FE, 3);
        xfer(8'h00, v);
        check("R2 stream 0", v, 8'h7E);
        xfer(8'h00, v);
        check("R2 stream 1", v, 8'h7F);
        xfer(8'h00, v);
        check("R2 stream 2 erased", v, 8'hFF);
        close_txn();
    endtask

    task automatic t_nodie;
        logic [7:0] v;
        simple_cmd(1, 8'h06);
        erase_cmd(1, 8'hC4, 32'h000100, 3);
        check("R7 single pulse", err_b_cnt, 1);
        get_status(1, v);
        check("R7 latch cleared, not busy", v, 8'h00);
        read_one(1, 3, 32'h100, v);
        check("R7 byte kept", v, 8'h00);
    endtask

    task automatic t_bulk;
        logic [7:0] v;
        simple_cmd(1, 8'h06);
        erase_cmd(1, 8'hC7, 32'h0, 0);
        tick(ERASE + 200);
        read_one(1, 3, 32'h000, v);
        check("R6 no-die bulk low", v, 8'hFF);
        read_one(1, 3, 32'h3FF, v);
        check("R6 no-die bulk high", v, 8'hFF);
        simple_cmd(0, 8'h06);
        erase_cmd(0, 8'hC7, 32'h0, 0);
        tick(ERASE + 200);
        read_one(0, 3, 32'h055, v);
        check("R6 bulk on dies", v, 8'hFF);
        check("R7 total pulses", err_b_cnt, 1);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_no_wel();
        t_partial();
        t_sector_busy();
        t_die3();
        t_die4();
        t_stream();
        t_nodie();
        t_bulk();
        report();
        $finish;
    end

endmodule